// File: doc/BRIEF.md
# Memory Region Scan Engine

This engine walks a contiguous byte range of memory and folds every byte it reads into one of two results. It is launched by a single-cycle start pulse carrying a four-bit operation code, a start address and a byte count. It then issues one read at a time on a simple request/acknowledge byte bus. The address advances by one after every acknowledged byte.

In erase-check mode the engine checks that the range reads back as all-ones, as an erased flash does. It halts at the first byte that is not 8'hFF. In CRC mode it computes the standard Ethernet CRC-32 over the whole range. Both modes report the address of the last byte read and a 32-bit value, and signal completion with a one-cycle done strobe. The surrounding sequencer owns command queuing, so the engine accepts a new job only while it is idle.

Top module: `region_scan`

## Requirements
- R1: A start pulse is accepted only when the engine is idle and `op_i` is 4'b0101 (erase-check) or 4'b0111 (CRC). Any other code leaves `busy_o`, `done_o`, `mem_req_o` and the results unchanged.
- R2: A start pulse while `busy_o` is high is ignored. The running scan continues with its own address, count and mode, and the results it reports are unaffected.
- R3: While scanning, `mem_req_o` stays high and `mem_addr_o` stays stable until `mem_ack_i`. The byte on `mem_data_i` is taken in the ack cycle. The first address is `addr_i`, and each later one is the previous plus one, modulo 2^ADDR_W.
- R4: `busy_o` rises in the cycle after an accepted start with a nonzero count. `done_o` is a one-cycle pulse in the cycle after the final ack, and `busy_o` is low in that cycle.
- R5: `res_addr_o` is the address of the last byte read.
- R6: In erase-check mode `res_val_o` is 24'hFFFFFF above the last byte read, so 32'hFFFFFFFF means that every byte in the range was 8'hFF.
- R7: In erase-check mode, the first byte that is not 8'hFF ends the scan. No further read is issued, and the result reports that byte and its address.
- R8: In CRC mode `res_val_o` is the reflected CRC-32 of the bytes in address order. It uses polynomial 32'hEDB88320, a preset of 32'hFFFFFFFF and a final inversion, so the bytes "123456789" give 32'hCBF43926.
- R9: A count of zero issues no read. `done_o` pulses in the cycle after the start, with `res_addr_o` equal to `addr_i` and `res_val_o` equal to 32'h00000000 (CRC) or 32'hFFFFFFFF (erase-check).
- R10: `res_addr_o` and `res_val_o` change only at the edge that raises `done_o`, and hold their values until the next completion.
- R11: During synchronous active-low reset, `busy_o`, `done_o` and `mem_req_o` go low and both result outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-cycle job launch |
| op_i | input | 4 | Operation code: 0101 erase-check, 0111 CRC |
| addr_i | input | ADDR_W | First byte address |
| count_i | input | CNT_W | Number of bytes to scan |
| mem_req_o | output | 1 | Read request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Byte address of the pending read |
| mem_ack_i | input | 1 | Read acknowledge; data valid in this cycle |
| mem_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion strobe |
| res_addr_o | output | ADDR_W | Last address read |
| res_val_o | output | 32 | Erase-check word or CRC-32 |

## Verification
The bench builds the engine with its default 32-bit address and 32-bit count. The full address width makes the wrap from 32'hFFFFFFFF to zero reachable within a four-byte scan, and the bench checks it against a 256-byte memory model indexed by the low address byte. Acknowledge latencies from zero to three cycles cover both back-to-back beats and held requests. A start pulse is injected during a scan, and an early stop on a non-erased byte is placed in the middle of a range.

// File: rtl/scan_pkg.sv
// Shared definitions for the region scan engine.
// Assumes a byte-wide read bus and a 32-bit result word.
package scan_pkg;
    typedef enum logic [0:0] {
        SCAN_CHECK = 1'b0,
        SCAN_CRC   = 1'b1
    } scan_mode_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_READ = 1'b1
    } scan_state_e;

    localparam logic [3:0]  OP_CHECK  = 4'b0101;
    localparam logic [3:0]  OP_CRC    = 4'b0111;
    localparam int          BYTE_W    = 8;
    localparam int          RES_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
endpackage

// File: rtl/scan_seq.sv
// Scan sequencer: accepts a job, walks the address range one acknowledged
// byte at a time and flags completion. It assumes the memory holds
// mem_addr_o stable data in the cycle it raises mem_ack_i.
module scan_seq
    import scan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              mem_ack_i,
    input  logic              stop_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              accept_o,
    output logic              beat_o,
    output logic              finish_o,
    output scan_mode_e        mode_o,
    output logic [ADDR_W-1:0] fin_addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    scan_state_e       state_q;
    scan_mode_e        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic              done_q;
    logic              op_ok;
    logic              zero_job;
    logic              last_beat;

    // Decode the launch condition and the end of a scan.
    always_comb begin
        op_ok     = (op_i == OP_CHECK) || (op_i == OP_CRC);
        accept_o  = start_i && (state_q == ST_IDLE) && op_ok;
        zero_job  = accept_o && (count_i == '0);
        beat_o    = (state_q == ST_READ) && mem_ack_i;
        last_beat = beat_o && ((remain_q == CNT_ONE) || stop_i);
        finish_o  = zero_job || last_beat;
        mode_o    = accept_o ? ((op_i == OP_CRC) ? SCAN_CRC : SCAN_CHECK) : mode_q;
        fin_addr_o = accept_o ? addr_i : addr_q;
    end

    // State, address and remaining count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= SCAN_CHECK;
            addr_q   <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish_o;
            mode_q <= mode_o;
            if (accept_o && !zero_job) begin
                state_q  <= ST_READ;
                addr_q   <= addr_i;
                remain_q <= count_i;
            end else if (beat_o) begin
                if (last_beat) begin
                    state_q <= ST_IDLE;
                end else begin
                    addr_q   <= addr_q + ADDR_ONE;
                    remain_q <= remain_q - CNT_ONE;
                end
            end
        end
    end

    assign busy_o     = (state_q == ST_READ);
    assign mem_req_o  = (state_q == ST_READ);
    assign mem_addr_o = addr_q;
    assign done_o     = done_q;

    // R3: an unanswered request stays up with the same address.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R3: consecutive reads step the address by one.
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_req_o && mem_ack_i) ##1 mem_req_o) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_ONE));

    // R4: done is a single-cycle strobe seen while idle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R1: an unknown operation code starts nothing.
    p_bad_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i != OP_CHECK) && (op_i != OP_CRC)) |=> (!busy_o && !done_o));

    // R9: a zero-length job completes at once without a read.
    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ((op_i == OP_CHECK) || (op_i == OP_CRC)) && (count_i == '0))
        |=> (done_o && !mem_req_o));

    // R7: a stop request on a beat ends reading.
    p_early_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && stop_i) |=> (!mem_req_o && done_o));
endmodule

// File: rtl/scan_crc_acc.sv
// Byte-serial reflected CRC-32 accumulator. The step logic is unrolled
// over DATA_W bit stages. It assumes init_i and beat_i are never both high.
module scan_crc_acc
    import scan_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter logic [31:0] POLY   = CRC_POLY,
    parameter logic [31:0] SEED   = CRC_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [31:0]       crc_o
);
    localparam int PAD_W = 32 - DATA_W;

    logic [31:0] crc_q;
    logic [31:0] crc_d;
    logic [31:0] stage [DATA_W+1];

    assign stage[0] = crc_q ^ {{PAD_W{1'b0}}, data_i};

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // One shift of the LSB-first division.
        assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
    end

    // Select the next remainder value.
    always_comb begin
        if (init_i)      crc_d = SEED;
        else if (beat_i) crc_d = stage[DATA_W];
        else             crc_d = crc_q;
    end

    // Remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc_o = ~crc_d;
endmodule

// File: rtl/scan_erase_chk.sv
// Erase checker: tracks the most recent byte and flags any byte that is
// not all-ones. It assumes init_i and beat_i are never both high.
module scan_erase_chk #(
    parameter int DATA_W = 8,
    parameter int RES_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bad_o,
    output logic [RES_W-1:0]  word_o
);
    localparam int EXT_W = RES_W - DATA_W;

    logic [DATA_W-1:0] last_q;
    logic [DATA_W-1:0] last_d;

    // Pick the byte to remember.
    always_comb begin
        if (init_i)      last_d = '1;
        else if (beat_i) last_d = data_i;
        else             last_d = last_q;
    end

    // Last-byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '1;
        else        last_q <= last_d;
    end

    assign bad_o  = (data_i != '1);
    assign word_o = {{EXT_W{1'b1}}, last_d};
endmodule

// File: rtl/region_scan.sv
// Region scan engine top: joins the sequencer, CRC accumulator and erase
// checker, and registers the reported address and value at completion.
// It assumes the sequencer upstream pulses start_i for one cycle.
module region_scan
    import scan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic [31:0]       res_val_o
);
    logic              accept;
    logic              beat;
    logic              finish;
    logic              bad_byte;
    logic              stop;
    scan_mode_e        mode;
    logic [ADDR_W-1:0] fin_addr;
    logic [RES_W-1:0]  crc_word;
    logic [RES_W-1:0]  chk_word;
    logic [ADDR_W-1:0] res_addr_q;
    logic [RES_W-1:0]  res_val_q;

    assign stop = (mode == SCAN_CHECK) && bad_byte;

    scan_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .addr_i     (addr_i),
        .count_i    (count_i),
        .mem_ack_i  (mem_ack_i),
        .stop_i     (stop),
        .busy_o     (busy_o),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o),
        .accept_o   (accept),
        .beat_o     (beat),
        .finish_o   (finish),
        .mode_o     (mode),
        .fin_addr_o (fin_addr),
        .done_o     (done_o)
    );

    scan_crc_acc #(
        .DATA_W (BYTE_W)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (accept),
        .beat_i (beat),
        .data_i (mem_data_i),
        .crc_o  (crc_word)
    );

    scan_erase_chk #(
        .DATA_W (BYTE_W),
        .RES_W  (RES_W)
    ) u_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (accept),
        .beat_i (beat),
        .data_i (mem_data_i),
        .bad_o  (bad_byte),
        .word_o (chk_word)
    );

    // Capture the reported address and value when a job completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_addr_q <= '0;
            res_val_q  <= '0;
        end else if (finish) begin
            res_addr_q <= fin_addr;
            res_val_q  <= (mode == SCAN_CRC) ? crc_word : chk_word;
        end
    end

    assign res_addr_o = res_addr_q;
    assign res_val_o  = res_val_q;

    // R10: results move only together with the done strobe.
    p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(res_addr_o) && $stable(res_val_o)));

    // R2: a start while busy does not disturb the pending read.
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !mem_ack_i) |=> (busy_o && $stable(mem_addr_o)));
endmodule

// File: tb/region_scan_bench.sv
// Bench for region_scan: a behavioural model steps on each rising edge and
// every output is compared on the falling edge.
module region_scan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = 4'h0;
    logic [31:0] addr_i = '0;
    logic [31:0] count_i = '0;
    logic        mem_ack_i = 1'b0;
    logic [7:0]  mem_data_i = 8'h00;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        busy_o;
    logic        done_o;
    logic [31:0] res_addr_o;
    logic [31:0] res_val_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  mem [256];
    int          lat = 0;
    logic        m_busy = 1'b0;
    logic        m_done = 1'b0;
    logic        m_crc_mode = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_left = '0;
    logic [31:0] m_crc = '0;
    logic [31:0] m_res_addr = '0;
    logic [31:0] m_res_val = '0;
    int          m_wait = 0;

    always #10 clk = ~clk;

    region_scan u_region_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .addr_i     (addr_i),
        .count_i    (count_i),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o),
        .mem_ack_i  (mem_ack_i),
        .mem_data_i (mem_data_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .res_addr_o (res_addr_o),
        .res_val_o  (res_val_o)
    );

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model of the scan engine.
    always @(posedge clk) begin
        logic [7:0] b;
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_addr = '0; m_left = '0;
            m_res_addr = '0; m_res_val = '0; m_wait = 0; m_crc_mode = 1'b0;
        end else begin
            m_done = 1'b0;
            if (!m_busy) begin
                if (start_i && (op_i == 4'b0101 || op_i == 4'b0111)) begin
                    m_crc_mode = (op_i == 4'b0111);
                    if (count_i == 0) begin
                        m_done = 1'b1;
                        m_res_addr = addr_i;
                        m_res_val = m_crc_mode ? 32'h0 : 32'hFFFFFFFF;
                    end else begin
                        m_busy = 1'b1; m_addr = addr_i; m_left = count_i;
                        m_crc = 32'hFFFFFFFF; m_wait = lat;
                    end
                end
            end else if (mem_ack_i) begin
                b = mem[m_addr[7:0]];
                m_crc = crc_byte(m_crc, b);
                if ((!m_crc_mode && b != 8'hFF) || m_left == 1) begin
                    m_busy = 1'b0; m_done = 1'b1; m_res_addr = m_addr;
                    m_res_val = m_crc_mode ? ~m_crc : {24'hFFFFFF, b};
                end else begin
                    m_addr = m_addr + 1; m_left = m_left - 1; m_wait = lat;
                end
            end else if (m_wait > 0) begin
                m_wait = m_wait - 1;
            end
        end
    end

    // Per-cycle comparison and memory response.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 busy_o", {31'h0, busy_o}, {31'h0, m_busy});
            chk("R3 mem_req_o", {31'h0, mem_req_o}, {31'h0, m_busy});
            if (m_busy) chk("R3 mem_addr_o", mem_addr_o, m_addr);
            chk("R4 done_o", {31'h0, done_o}, {31'h0, m_done});
            chk("R5 res_addr_o", res_addr_o, m_res_addr);
            chk("R10 res_val_o", res_val_o, m_res_val);
        end
        mem_ack_i  = m_busy && (m_wait == 0);
        mem_data_i = mem_ack_i ? mem[m_addr[7:0]] : 8'h00;
    end

    task automatic launch(input logic [3:0] op, input logic [31:0] a, input logic [31:0] n, input int l);
        @(negedge clk);
        lat = l; start_i = 1'b1; op_i = op; addr_i = a; count_i = n;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_job();
        while (m_busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        for (int i = 0; i < 9; i++) mem[8'h10 + i] = 8'h31 + 8'(i);
        for (int i = 0; i < 64; i++) mem[8'h40 + i] = 8'(i * 37);
        mem[8'h85] = 8'h7E;
        mem[8'hFE] = 8'h12;
        mem[8'hFF] = 8'h34;

        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 busy_o", {31'h0, busy_o}, 32'h0);
        chk("R11 done_o", {31'h0, done_o}, 32'h0);
        chk("R11 mem_req_o", {31'h0, mem_req_o}, 32'h0);
        chk("R11 res_addr_o", res_addr_o, 32'h0);
        chk("R11 res_val_o", res_val_o, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 unknown op codes are ignored
        launch(4'b0110, 32'h10, 32'd5, 0);
        chk("R1 no busy", {31'h0, busy_o}, 32'h0);
        launch(4'b1101, 32'h10, 32'd0, 0);
        chk("R1 no done", {31'h0, done_o}, 32'h0);

        // R8 known check value
        launch(4'b0111, 32'h10, 32'd9, 0);
        finish_job();
        chk("R8 crc 123456789", res_val_o, 32'hCBF43926);
        chk("R5 crc last addr", res_addr_o, 32'h18);

        // R6 erased range with held requests
        launch(4'b0101, 32'h90, 32'd16, 2);
        finish_job();
        chk("R6 erased word", res_val_o, 32'hFFFFFFFF);
        chk("R5 erased last addr", res_addr_o, 32'h9F);

        // R7 early stop at the first non-erased byte
        launch(4'b0101, 32'h80, 32'd16, 1);
        finish_job();
        chk("R7 stop word", res_val_o, 32'hFFFFFF7E);
        chk("R7 stop addr", res_addr_o, 32'h85);
        repeat (2) @(negedge clk);
        chk("R7 no further read", {31'h0, mem_req_o}, 32'h0);

        // R9 zero-length jobs
        launch(4'b0111, 32'h1234, 32'd0, 0);
        chk("R9 crc zero val", res_val_o, 32'h0);
        chk("R9 crc zero addr", res_addr_o, 32'h1234);
        launch(4'b0101, 32'h55AA, 32'd0, 0);
        chk("R9 check zero val", res_val_o, 32'hFFFFFFFF);
        chk("R9 check zero addr", res_addr_o, 32'h55AA);

        // R2 start pulse in the middle of a scan
        launch(4'b0101, 32'hA0, 32'd6, 3);
        @(negedge clk);
        start_i = 1'b1; op_i = 4'b0111; addr_i = 32'h10; count_i = 32'd1;
        @(negedge clk);
        start_i = 1'b0;
        finish_job();
        chk("R2 busy start ignored addr", res_addr_o, 32'hA5);
        chk("R2 busy start ignored val", res_val_o, 32'hFFFFFFFF);

        // R3 address wrap across the top of the address space
        launch(4'b0111, 32'hFFFFFFFE, 32'd4, 1);
        finish_job();
        chk("R3 wrap last addr", res_addr_o, 32'h1);

        // R8 longer region with mixed latency
        launch(4'b0111, 32'h40, 32'd64, 0);
        finish_job();
        launch(4'b0111, 32'h40, 32'd64, 3);
        finish_job();

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule